// File: doc/BRIEF.md
# SD Card Data FIFO with Threshold Flags

This block buffers data words between a processor-visible data port and the serial data-line engine of an SD card host. It holds sixteen 32-bit words. While a transfer runs it raises one status flag shared by both directions. On a card read the flag means "enough words to collect". On a card write it means "enough room to refill". Each direction has its own programmable threshold. A sticky error bit is set when either side pushes into a full buffer or pops an empty one.

The block also counts the bytes of each block and the blocks that remain. It sets a block-complete status bit every time the engine moves the last byte of a block. After the final block it drops back to the idle data state. A debug word reports four things: the engine state code, the fill level, both thresholds, and a write-only force bit that parks the engine in the data state. The interrupt output combines the data flag and the block bit, each gated by its own enable input.

Top module: `sdx_data_fifo`

## Requirements
- R1: After reset the debug word reads 0x00010801. This means state code 1 (data) in bits 3:0, fill 0 in bits 8:4, write threshold 4 in bits 13:9 and read threshold 4 in bits 18:14. The status word and `irq` are 0.
- R2: Words leave the buffer in the order they entered, and the fill field in bits 8:4 follows the word count up to 16. In read direction the engine fills and the host drains. Otherwise the host fills and the engine drains. Read direction is set by a transfer start with `xfer_rd`=1, and write direction is the reset default.
- R3: A push into a full buffer (without a simultaneous pop) is dropped and sets status bit 3. A pop from an empty buffer also sets status bit 3. The fill level does not change in either case, and the bit stays set until cleared.
- R4: During a read transfer, status bit 0 is 1 exactly when fill >= read threshold.
- R5: During a write transfer, status bit 0 is 1 exactly when (16 - fill) >= write threshold. With no transfer active, bit 0 is 0.
- R6: `irq` = (status bit 0 AND `cfg_data_irq_en`) OR (status bit 9 AND `cfg_block_irq_en`).
- R7: Each accepted engine beat counts 4 bytes. When the bytes of a block reach the programmed block size, status bit 9 is set and the remaining block count drops by one. After the last block the state code returns to 1. A start with a block count of 0 leaves the state at 1.
- R8: While a transfer is active the state code is one of four values: 2 for a read with room, 4 for a read with a full buffer, 3 for a write with data, and 0xA for a write with an empty buffer.
- R9: A debug write with bit 19 set ends any transfer at once. The state code becomes 1, and later engine beats set no block bit.
- R10: A clear strobe with bit 9 or bit 3 set in `hsts_clr_data` clears that status bit. A new event in the same cycle wins over the clear.
- R11: A debug write loads the write threshold from bits 13:9 and the read threshold from bits 18:14. Both read back at the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_push | input | 1 | Host writes a word (write direction) |
| host_wdata | input | 32 | Host write word |
| host_pop | input | 1 | Host reads a word (read direction) |
| host_rdata | output | 32 | Head word of the buffer |
| eng_push | input | 1 | Engine delivers a card word (read direction) |
| eng_wdata | input | 32 | Engine word in |
| eng_pop | input | 1 | Engine takes a word for the card (write direction) |
| eng_rdata | output | 32 | Head word of the buffer |
| xfer_start | input | 1 | Start a transfer |
| xfer_rd | input | 1 | 1 = card-to-host direction |
| xfer_bytes | input | 32 | Bytes per block |
| xfer_blocks | input | 9 | Number of blocks |
| ctl_we | input | 1 | Debug word write strobe |
| ctl_wdata | input | 20 | Debug write data (thresholds, force bit 19) |
| hsts_clr_we | input | 1 | Status clear strobe |
| hsts_clr_data | input | 10 | Status bits to clear (9 and 3 used) |
| cfg_data_irq_en | input | 1 | Data flag interrupt enable |
| cfg_block_irq_en | input | 1 | Block interrupt enable |
| dbg_word | output | 32 | State, fill level, thresholds |
| sts_word | output | 32 | Bit 9 block, bit 3 FIFO error, bit 0 data flag |
| irq | output | 1 | Qualified interrupt |

## Verification
The bench aims at the full/empty edges. A buffer that accepts a seventeenth word would show a fill of 0 or overwrite the oldest word. A buffer that misses an underrun would leave bit 3 clear. Threshold comparisons are tested one word either side of the trip point, so an off-by-one in the `>=` shows up as a flag that rises one word late or early. The block counter is run across several blocks with the buffer parked full, which catches a counter that stops early or fails to return to the data state. The force and zero-block cases catch a design that keeps counting after it was told to stop.

// File: rtl/sdx_fifo_pkg.sv
package sdx_fifo_pkg;
   typedef enum logic [3:0] {
      ST_IDENT        = 4'h0,
      ST_DATA         = 4'h1,
      ST_RD_DATA      = 4'h2,
      ST_WR_DATA      = 4'h3,
      ST_RD_WAIT      = 4'h4,
      ST_RD_CRC       = 4'h5,
      ST_WR_CRC       = 4'h6,
      ST_WR_WAIT1     = 4'h7,
      ST_PWR_DN       = 4'h8,
      ST_PWR_UP       = 4'h9,
      ST_WR_START1    = 4'hA,
      ST_WR_START2    = 4'hB,
      ST_GEN_PULSE    = 4'hC,
      ST_WR_WAIT2     = 4'hD,
      ST_START_PWR_DN = 4'hF
   } eng_state_e;

   localparam int THR_W     = 5;
   localparam int FILL_LSB  = 4;
   localparam int WTHR_LSB  = 9;
   localparam int RTHR_LSB  = 14;
   localparam int FORCE_BIT = 19;
   localparam int STS_FLAG  = 0;
   localparam int STS_FERR  = 3;
   localparam int STS_BLK   = 9;
endpackage

// File: rtl/sdx_fifo_store.sv
module sdx_fifo_store #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [CW-1:0]    fill,
   output logic             push_acc,
   output logic             pop_acc,
   output logic             overrun,
   output logic             underrun
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             full, empty;

   assign full     = (fill == CW'(DEPTH));
   assign empty    = (fill == '0);
   assign pop_acc  = pop & ~empty;
   assign push_acc = push & (~full | pop_acc);
   assign overrun  = push & full & ~pop_acc;
   assign underrun = pop & empty;
   assign rdata    = mem[rd_ptr];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk) begin
         if (push_acc && wr_ptr == AW'(g)) mem[g] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push_acc) wr_ptr <= wr_ptr + 1'b1;
         if (pop_acc)  rd_ptr <= rd_ptr + 1'b1;
         fill <= fill + CW'(push_acc) - CW'(pop_acc);
      end
   end
endmodule

// File: rtl/sdx_blk_track.sv
module sdx_blk_track #(
   parameter int BYTES_W = 32,
   parameter int BLK_W   = 9,
   parameter int BPW     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               start_rd,
   input  logic [BYTES_W-1:0] blk_bytes,
   input  logic [BLK_W-1:0]   blk_cnt,
   input  logic               beat,
   input  logic               abort,
   output logic               active,
   output logic               is_rd,
   output logic               block_done
);
   logic [BYTES_W-1:0] bytes_len, bytes_done;
   logic [BLK_W-1:0]   blocks_left;
   logic [BYTES_W:0]   next_bytes;

   assign next_bytes = {1'b0, bytes_done} + (BYTES_W + 1)'(BPW);
   assign block_done = active & beat & ~abort & ~start
                       & (next_bytes >= {1'b0, bytes_len});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active      <= 1'b0;
         is_rd       <= 1'b0;
         bytes_len   <= '0;
         bytes_done  <= '0;
         blocks_left <= '0;
      end else if (abort) begin
         active <= 1'b0;
      end else if (start) begin
         is_rd       <= start_rd;
         active      <= (blk_cnt != '0);
         bytes_len   <= blk_bytes;
         bytes_done  <= '0;
         blocks_left <= blk_cnt;
      end else if (active && beat) begin
         if (block_done) begin
            bytes_done  <= '0;
            blocks_left <= blocks_left - 1'b1;
            if (blocks_left == BLK_W'(1)) active <= 1'b0;
         end else begin
            bytes_done <= next_bytes[BYTES_W-1:0];
         end
      end
   end
endmodule

// File: rtl/sdx_flag_gen.sv
module sdx_flag_gen
   import sdx_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic             active,
   input  logic             is_rd,
   input  logic [CW-1:0]    fill,
   input  logic [THR_W-1:0] rd_thr,
   input  logic [THR_W-1:0] wr_thr,
   output logic             data_flag,
   output eng_state_e       state_code
);
   logic [THR_W:0] fill_x, free_x;

   assign fill_x = (THR_W + 1)'(fill);
   assign free_x = (THR_W + 1)'(DEPTH) - fill_x;

   always_comb begin
      data_flag  = 1'b0;
      state_code = ST_DATA;
      if (active) begin
         if (is_rd) begin
            data_flag  = (fill_x >= {1'b0, rd_thr});
            state_code = (fill_x == (THR_W + 1)'(DEPTH)) ? ST_RD_WAIT : ST_RD_DATA;
         end else begin
            data_flag  = (free_x >= {1'b0, wr_thr});
            state_code = (fill_x == '0) ? ST_WR_START1 : ST_WR_DATA;
         end
      end
   end
endmodule

// File: rtl/sdx_data_fifo.sv
module sdx_data_fifo
   import sdx_fifo_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int DEPTH     = 16,
   parameter int BYTES_W   = 32,
   parameter int BLK_W     = 9,
   parameter int THR_RESET = 4,
   localparam int CW  = $clog2(DEPTH) + 1,
   localparam int BPW = WIDTH / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_push,
   input  logic [WIDTH-1:0]   host_wdata,
   input  logic               host_pop,
   output logic [WIDTH-1:0]   host_rdata,
   input  logic               eng_push,
   input  logic [WIDTH-1:0]   eng_wdata,
   input  logic               eng_pop,
   output logic [WIDTH-1:0]   eng_rdata,
   input  logic               xfer_start,
   input  logic               xfer_rd,
   input  logic [BYTES_W-1:0] xfer_bytes,
   input  logic [BLK_W-1:0]   xfer_blocks,
   input  logic               ctl_we,
   input  logic [19:0]        ctl_wdata,
   input  logic               hsts_clr_we,
   input  logic [9:0]         hsts_clr_data,
   input  logic               cfg_data_irq_en,
   input  logic               cfg_block_irq_en,
   output logic [31:0]        dbg_word,
   output logic [31:0]        sts_word,
   output logic               irq
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2 || DEPTH > 16) begin : g_bad_depth
      $error("DEPTH must be a power of two from 2 to 16");
   end
   if (WIDTH % 8 != 0) begin : g_bad_width
      $error("WIDTH must be whole bytes");
   end
   if (THR_RESET > DEPTH) begin : g_bad_thr
      $error("THR_RESET exceeds DEPTH");
   end

   logic             active, is_rd, block_done, data_flag, force_data;
   logic             fifo_push, fifo_pop, push_acc, pop_acc, overrun, underrun;
   logic [WIDTH-1:0] fifo_wdata, head;
   logic [CW-1:0]    fill;
   logic [THR_W-1:0] rd_thr, wr_thr;
   logic             sts_ferr, sts_blk, eng_beat;
   eng_state_e       state_code;

   assign fifo_push  = is_rd ? eng_push  : host_push;
   assign fifo_wdata = is_rd ? eng_wdata : host_wdata;
   assign fifo_pop   = is_rd ? host_pop  : eng_pop;
   assign eng_beat   = is_rd ? (eng_push & push_acc) : (eng_pop & pop_acc);
   assign force_data = ctl_we & ctl_wdata[FORCE_BIT];
   assign host_rdata = head;
   assign eng_rdata  = head;

   sdx_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk, .rst_n, .push(fifo_push), .wdata(fifo_wdata), .pop(fifo_pop),
      .rdata(head), .fill, .push_acc, .pop_acc, .overrun, .underrun
   );

   sdx_blk_track #(.BYTES_W(BYTES_W), .BLK_W(BLK_W), .BPW(BPW)) u_track (
      .clk, .rst_n, .start(xfer_start), .start_rd(xfer_rd),
      .blk_bytes(xfer_bytes), .blk_cnt(xfer_blocks), .beat(eng_beat),
      .abort(force_data), .active, .is_rd, .block_done
   );

   sdx_flag_gen #(.DEPTH(DEPTH)) u_flag (
      .active, .is_rd, .fill, .rd_thr, .wr_thr, .data_flag, .state_code
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_thr   <= THR_W'(THR_RESET);
         wr_thr   <= THR_W'(THR_RESET);
         sts_ferr <= 1'b0;
         sts_blk  <= 1'b0;
      end else begin
         if (ctl_we) begin
            rd_thr <= ctl_wdata[RTHR_LSB +: THR_W];
            wr_thr <= ctl_wdata[WTHR_LSB +: THR_W];
         end
         if (overrun || underrun)                  sts_ferr <= 1'b1;
         else if (hsts_clr_we && hsts_clr_data[STS_FERR]) sts_ferr <= 1'b0;
         if (block_done)                           sts_blk <= 1'b1;
         else if (hsts_clr_we && hsts_clr_data[STS_BLK])  sts_blk <= 1'b0;
      end
   end

   always_comb begin
      dbg_word = '0;
      dbg_word[3:0]                 = state_code;
      dbg_word[FILL_LSB +: THR_W]   = THR_W'(fill);
      dbg_word[WTHR_LSB +: THR_W]   = wr_thr;
      dbg_word[RTHR_LSB +: THR_W]   = rd_thr;
      sts_word = '0;
      sts_word[STS_FLAG] = data_flag;
      sts_word[STS_FERR] = sts_ferr;
      sts_word[STS_BLK]  = sts_blk;
   end

   assign irq = (data_flag & cfg_data_irq_en) | (sts_blk & cfg_block_irq_en);
endmodule

// File: rtl/sdx_data_fifo_chk.sv
module sdx_data_fifo_chk #(
   parameter int DEPTH = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        fifo_push,
   input logic        fifo_pop,
   input logic        ctl_we,
   input logic [19:0] ctl_wdata,
   input logic        hsts_clr_we,
   input logic [9:0]  hsts_clr_data,
   input logic        cfg_data_irq_en,
   input logic        cfg_block_irq_en,
   input logic [31:0] dbg_word,
   input logic [31:0] sts_word,
   input logic        irq
);
   logic [4:0] fill_f;
   assign fill_f = dbg_word[8:4];

   a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill_f <= 5'(DEPTH));

   a_r2_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_f == $past(fill_f)) || (fill_f == $past(fill_f) + 5'd1)
      || (fill_f + 5'd1 == $past(fill_f)));

   a_r3_overrun_err: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_push && !fifo_pop && fill_f == 5'(DEPTH)) |=> sts_word[3]);

   a_r3_underrun_err: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && fill_f == 5'd0) |=> sts_word[3]);

   a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_word[3] && !(hsts_clr_we && hsts_clr_data[3])) |=> sts_word[3]);

   a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_data_irq_en && !cfg_block_irq_en) |-> !irq);

   a_r9_force_data: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[19]) |=> (dbg_word[3:0] == 4'h1));
endmodule

bind sdx_data_fifo sdx_data_fifo_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
   .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .hsts_clr_we(hsts_clr_we),
   .hsts_clr_data(hsts_clr_data), .cfg_data_irq_en(cfg_data_irq_en),
   .cfg_block_irq_en(cfg_block_irq_en), .dbg_word(dbg_word),
   .sts_word(sts_word), .irq(irq)
);

// File: tb/sdx_data_fifo_bench.sv
`timescale 1ns/1ps
module sdx_data_fifo_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_push = 0, host_pop = 0, eng_push = 0, eng_pop = 0;
   logic [31:0] host_wdata = '0, eng_wdata = '0;
   logic [31:0] host_rdata, eng_rdata, dbg_word, sts_word;
   logic        xfer_start = 0, xfer_rd = 0;
   logic [31:0] xfer_bytes = '0;
   logic [8:0]  xfer_blocks = '0;
   logic        ctl_we = 0, hsts_clr_we = 0;
   logic [19:0] ctl_wdata = '0;
   logic [9:0]  hsts_clr_data = '0;
   logic        cfg_data_irq_en = 0, cfg_block_irq_en = 0;
   logic        irq;
   int          vectors = 0, fails = 0;
   bit          finished = 0;

   always #2.5 clk = ~clk;

   sdx_data_fifo u_sdx_data_fifo (
      .clk, .rst_n, .host_push, .host_wdata, .host_pop, .host_rdata,
      .eng_push, .eng_wdata, .eng_pop, .eng_rdata, .xfer_start, .xfer_rd,
      .xfer_bytes, .xfer_blocks, .ctl_we, .ctl_wdata, .hsts_clr_we,
      .hsts_clr_data, .cfg_data_irq_en, .cfg_block_irq_en, .dbg_word,
      .sts_word, .irq
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic hpush(logic [31:0] d);
      host_push = 1; host_wdata = d; step(); host_push = 0;
   endtask
   task automatic epush(logic [31:0] d);
      eng_push = 1; eng_wdata = d; step(); eng_push = 0;
   endtask
   task automatic hpop(string req, logic [31:0] exp);
      check(req, host_rdata, exp); host_pop = 1; step(); host_pop = 0;
   endtask
   task automatic epop(string req, logic [31:0] exp);
      check(req, eng_rdata, exp); eng_pop = 1; step(); eng_pop = 0;
   endtask
   task automatic ctl(logic [19:0] d);
      ctl_we = 1; ctl_wdata = d; step(); ctl_we = 0;
   endtask
   task automatic clr(logic [9:0] m);
      hsts_clr_we = 1; hsts_clr_data = m; step(); hsts_clr_we = 0;
   endtask
   task automatic start(logic rd, logic [31:0] b, logic [8:0] n);
      xfer_start = 1; xfer_rd = rd; xfer_bytes = b; xfer_blocks = n;
      step(); xfer_start = 0;
   endtask

   task automatic t_reset();
      check("R1 dbg", dbg_word, 32'h0001_0801);
      check("R1 sts", sts_word, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_order();
      for (int i = 0; i < 5; i++) hpush(32'h1100_0000 + i);
      check("R2 fill 5", {27'b0, dbg_word[8:4]}, 32'd5);
      check("R5 idle flag", {31'b0, sts_word[0]}, 32'd0);
      for (int i = 0; i < 5; i++) epop("R2 order", 32'h1100_0000 + i);
      check("R2 fill 0", {27'b0, dbg_word[8:4]}, 32'd0);
      check("R3 no err", {31'b0, sts_word[3]}, 32'd0);
   endtask

   task automatic t_overrun();
      for (int i = 0; i < 16; i++) hpush(32'h2200_0000 + i);
      check("R2 fill full", {27'b0, dbg_word[8:4]}, 32'd16);
      check("R3 no err yet", {31'b0, sts_word[3]}, 32'd0);
      hpush(32'hDEAD_BEEF);
      check("R3 overrun err", {31'b0, sts_word[3]}, 32'd1);
      check("R3 fill held", {27'b0, dbg_word[8:4]}, 32'd16);
      clr(10'h008);
      check("R10 err cleared", {31'b0, sts_word[3]}, 32'd0);
      for (int i = 0; i < 16; i++) epop("R3 kept oldest", 32'h2200_0000 + i);
      eng_pop = 1; step(); eng_pop = 0;
      check("R3 underrun err", {31'b0, sts_word[3]}, 32'd1);
      check("R3 fill still 0", {27'b0, dbg_word[8:4]}, 32'd0);
      clr(10'h008);
   endtask

   task automatic t_read();
      ctl(20'h1_9400);
      check("R11 thresholds", dbg_word, 32'h0001_9401);
      start(1'b1, 32'd32, 9'd3);
      check("R8 read state", {28'b0, dbg_word[3:0]}, 32'h2);
      for (int i = 0; i < 5; i++) epush(32'h3300_0000 + i);
      check("R4 below thr", {31'b0, sts_word[0]}, 32'd0);
      epush(32'h3300_0005);
      check("R4 at thr", {31'b0, sts_word[0]}, 32'd1);
      check("R6 gated off", {31'b0, irq}, 32'd0);
      cfg_data_irq_en = 1; #0.1;
      check("R6 data irq", {31'b0, irq}, 32'd1);
      cfg_data_irq_en = 0;
      epush(32'h3300_0006);
      check("R7 no blk at 7", {31'b0, sts_word[9]}, 32'd0);
      epush(32'h3300_0007);
      check("R7 blk after 8", {31'b0, sts_word[9]}, 32'd1);
      cfg_block_irq_en = 1; #0.1;
      check("R6 block irq", {31'b0, irq}, 32'd1);
      clr(10'h200);
      check("R10 blk cleared", {30'b0, sts_word[9], irq}, 32'd0);
      cfg_block_irq_en = 0;
      for (int i = 8; i < 16; i++) epush(32'h3300_0000 + i);
      check("R8 read wait", {28'b0, dbg_word[3:0]}, 32'h4);
      check("R7 blk 2", {31'b0, sts_word[9]}, 32'd1);
      clr(10'h200);
      for (int i = 0; i < 8; i++) hpop("R2 read order", 32'h3300_0000 + i);
      check("R8 back to rd", {28'b0, dbg_word[3:0]}, 32'h2);
      for (int i = 16; i < 24; i++) epush(32'h3300_0000 + i);
      check("R7 last blk", {31'b0, sts_word[9]}, 32'd1);
      check("R7 back to data", {28'b0, dbg_word[3:0]}, 32'h1);
      for (int i = 8; i < 24; i++) hpop("R2 read order", 32'h3300_0000 + i);
      clr(10'h200);
   endtask

   task automatic t_write();
      start(1'b0, 32'd8, 9'd2);
      check("R8 write start", {28'b0, dbg_word[3:0]}, 32'hA);
      check("R5 free>=thr", {31'b0, sts_word[0]}, 32'd1);
      for (int i = 0; i < 6; i++) hpush(32'h4400_0000 + i);
      check("R5 free 10", {31'b0, sts_word[0]}, 32'd1);
      hpush(32'h4400_0006);
      check("R5 free 9", {31'b0, sts_word[0]}, 32'd0);
      check("R8 write data", {28'b0, dbg_word[3:0]}, 32'h3);
      epop("R2 write order", 32'h4400_0000);
      epop("R2 write order", 32'h4400_0001);
      check("R7 write blk", {31'b0, sts_word[9]}, 32'd1);
      epop("R2 write order", 32'h4400_0002);
      epop("R2 write order", 32'h4400_0003);
      check("R7 write done", {28'b0, dbg_word[3:0]}, 32'h1);
      check("R5 inactive flag", {31'b0, sts_word[0]}, 32'd0);
      for (int i = 4; i < 7; i++) epop("R2 write order", 32'h4400_0000 + i);
      clr(10'h200);
   endtask

   task automatic t_force();
      start(1'b1, 32'd16, 9'd4);
      epush(32'h5500_0000); epush(32'h5500_0001);
      ctl(20'h9_9400);
      check("R9 forced data", dbg_word, 32'h0001_9421);
      epush(32'h5500_0002); epush(32'h5500_0003);
      check("R9 no blk", {31'b0, sts_word[9]}, 32'd0);
      for (int i = 0; i < 4; i++) hpop("R9 data kept", 32'h5500_0000 + i);
      start(1'b1, 32'd16, 9'd0);
      check("R7 zero blocks", {28'b0, dbg_word[3:0]}, 32'h1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      t_reset();
      t_order();
      t_overrun();
      t_read();
      t_write();
      t_force();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule